// File: doc/BRIEF.md
# Operand Source Select Unit

This unit chooses the two 16-bit ALU operands for each cycle from the instruction fields that are already held in registers. The A operand comes from one of four internal sources: memory data, instruction-fetch data, the Q register or the T register. When none of these is chosen, it comes from an external A bus. A 3-bit A-select field normally picks the source. Three function codes, when the function is valid, replace that choice. A 2-bit sub-field at the top of the function field can also redirect two of the A-select values.

The B operand is either the register-bus input or a literal made from the 8-bit function field. The literal's other byte is zero-filled or one-filled, and the two bytes may be swapped. The unit also raises a memory-address-mux enable for two of the A-select values, and it reports which register-bus B source was chosen. All outputs are registered one clock after the inputs, and a synchronous active-high reset clears them.

Top module: `opsel_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output (`a_opnd`, `b_opnd`, `mar_mux_en`, `b_lit`, `b_src`) is zero after that edge.
- R2: With no override active, `asel`=5 gives `a_opnd` = `ifu_bus`, and `asel`=6 gives `a_opnd` = `t_bus`.
- R3: For `asel` 2 or 3 with `fn_valid`=1 and no override code, `ff[7:6]` picks A: 0 gives `md_bus`, 1 gives `ifu_bus`, 2 gives `q_bus`, 3 gives `t_bus`.
- R4: For `asel` 2 or 3 with `fn_valid`=0, A is `t_bus` whatever `ff` holds.
- R5: For `asel` 0, 1, 4 or 7 with no override, A is `ext_a_bus`. `mar_mux_en` is 1 exactly when `asel` is 0 or 1, and this holds even under an override.
- R6: With `fn_valid`=1, `fn_code` 8'o21 forces A to `t_bus`, 8'o22 forces it to `md_bus`, and 8'o23 forces it to `q_bus`. This takes precedence over every `asel` value.
- R7: For `bsel` 0 to 3, `b_opnd` = `rb_bus`, `b_src` = `bsel[1:0]` and `b_lit` = 0.
- R8: For `bsel` 4, `b_opnd` = {8'h00, ff}. For `bsel` 5, `b_opnd` = {8'hFF, ff}. In both cases `b_lit` = 1 and `b_src` = 0.
- R9: For `bsel` 6, `b_opnd` = {ff, 8'h00}. For `bsel` 7, `b_opnd` = {ff, 8'hFF}. This is the bsel 4/5 literal rotated by 8, with `b_lit` = 1.
- R10: Outputs change only at a rising edge. They reflect the inputs sampled at that edge and hold steady between edges.
- R11: When `fn_valid`=0, the override codes in `fn_code` have no effect on the A choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asel | input | 3 | A-select field |
| bsel | input | 3 | B-select field |
| ff | input | 8 | Function field, also the literal byte |
| fn_valid | input | 1 | Function field is valid this cycle |
| fn_code | input | 8 | Qualified function code |
| md_bus | input | 16 | Memory data source |
| ifu_bus | input | 16 | Instruction-fetch data source |
| q_bus | input | 16 | Q register source |
| t_bus | input | 16 | T register source |
| ext_a_bus | input | 16 | External A bus, used when no internal source is chosen |
| rb_bus | input | 16 | Register-bus B source |
| a_opnd | output | 16 | Selected A operand |
| b_opnd | output | 16 | Selected B operand |
| mar_mux_en | output | 1 | Memory-address mux enable |
| b_src | output | 2 | Register-bus B source code (0 when a literal is used) |
| b_lit | output | 1 | B operand is a literal |

## Verification
A function-code override of the A source can arrive in the same cycle as an A-select value that has its own meaning. One case is `asel` 0, which also raises the memory-address enable. Another is `asel` 2, whose `ff` sub-field points at a different source. The bench drives these pairs together with distinct constants on every bus. It then checks two things: the override source appears on `a_opnd`, and `mar_mux_en` still follows `asel` alone. The same vectors also pair each override with a literal B mode, to show that the A and B paths do not disturb each other.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
  typedef enum logic [2:0] {
    ASRC_MD  = 3'd0,
    ASRC_IFU = 3'd1,
    ASRC_Q   = 3'd2,
    ASRC_T   = 3'd3,
    ASRC_EXT = 3'd4
  } asrc_e;

  localparam int FN_FORCE_T  = 8'o21;
  localparam int FN_FORCE_MD = 8'o22;
  localparam int FN_FORCE_Q  = 8'o23;
endpackage

// File: rtl/opsel_asrc_dec.sv
module opsel_asrc_dec
  import opsel_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic [2:0]    asel,
  input  logic [FW-1:0] ff,
  input  logic          fn_valid,
  input  logic [FW-1:0] fn_code,
  output asrc_e         src,
  output logic          mar_en
);
  asrc_e base;

  always_comb begin
    mar_en = (asel == 3'd0) || (asel == 3'd1);
    case (asel)
      3'd2, 3'd3: base = fn_valid ? asrc_e'({1'b0, ff[FW-1:FW-2]}) : ASRC_T;
      3'd5:       base = ASRC_IFU;
      3'd6:       base = ASRC_T;
      default:    base = ASRC_EXT;
    endcase
    src = base;
    if (fn_valid) begin
      if (fn_code == FW'(FN_FORCE_T))       src = ASRC_T;
      else if (fn_code == FW'(FN_FORCE_MD)) src = ASRC_MD;
      else if (fn_code == FW'(FN_FORCE_Q))  src = ASRC_Q;
    end
  end
endmodule

// File: rtl/opsel_amux.sv
module opsel_amux
  import opsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  asrc_e         src,
  input  logic [DW-1:0] md_bus,
  input  logic [DW-1:0] ifu_bus,
  input  logic [DW-1:0] q_bus,
  input  logic [DW-1:0] t_bus,
  input  logic [DW-1:0] ext_a_bus,
  output logic [DW-1:0] a_val
);
  always_comb begin
    case (src)
      ASRC_MD:  a_val = md_bus;
      ASRC_IFU: a_val = ifu_bus;
      ASRC_Q:   a_val = q_bus;
      ASRC_T:   a_val = t_bus;
      default:  a_val = ext_a_bus;
    endcase
  end
endmodule

// File: rtl/opsel_bsel.sv
module opsel_bsel #(
  parameter int DW = 16
) (
  input  logic [2:0]      bsel,
  input  logic [DW/2-1:0] ff,
  input  logic [DW-1:0]   rb_bus,
  output logic [DW-1:0]   b_val,
  output logic [1:0]      b_src,
  output logic            b_lit
);
  localparam int LW = DW / 2;

  logic [LW-1:0] fill;
  logic [DW-1:0] lit;

  assign fill = bsel[0] ? {LW{1'b1}} : {LW{1'b0}};
  assign lit  = bsel[1] ? {ff, fill} : {fill, ff};

  always_comb begin
    b_lit = bsel[2];
    b_val = bsel[2] ? lit : rb_bus;
    b_src = bsel[2] ? 2'd0 : bsel[1:0];
  end
endmodule

// File: rtl/opsel_unit.sv
module opsel_unit
  import opsel_pkg::*;
#(
  parameter int DW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      asel,
  input  logic [2:0]      bsel,
  input  logic [DW/2-1:0] ff,
  input  logic            fn_valid,
  input  logic [DW/2-1:0] fn_code,
  input  logic [DW-1:0]   md_bus,
  input  logic [DW-1:0]   ifu_bus,
  input  logic [DW-1:0]   q_bus,
  input  logic [DW-1:0]   t_bus,
  input  logic [DW-1:0]   ext_a_bus,
  input  logic [DW-1:0]   rb_bus,
  output logic [DW-1:0]   a_opnd,
  output logic [DW-1:0]   b_opnd,
  output logic            mar_mux_en,
  output logic [1:0]      b_src,
  output logic            b_lit
);
  localparam int LW = DW / 2;

  asrc_e         src_c;
  logic          mar_c;
  logic [DW-1:0] a_c;
  logic [DW-1:0] b_c;
  logic [1:0]    bsrc_c;
  logic          blit_c;

  opsel_asrc_dec #(.FW(LW)) u_dec (
    .asel(asel), .ff(ff), .fn_valid(fn_valid), .fn_code(fn_code),
    .src(src_c), .mar_en(mar_c)
  );

  opsel_amux #(.DW(DW)) u_amux (
    .src(src_c), .md_bus(md_bus), .ifu_bus(ifu_bus), .q_bus(q_bus),
    .t_bus(t_bus), .ext_a_bus(ext_a_bus), .a_val(a_c)
  );

  opsel_bsel #(.DW(DW)) u_bsel (
    .bsel(bsel), .ff(ff), .rb_bus(rb_bus),
    .b_val(b_c), .b_src(bsrc_c), .b_lit(blit_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          a_opnd     <= '0;
          b_opnd     <= '0;
          mar_mux_en <= 1'b0;
          b_src      <= 2'd0;
          b_lit      <= 1'b0;
        end else begin
          a_opnd     <= a_c;
          b_opnd     <= b_c;
          mar_mux_en <= mar_c;
          b_src      <= bsrc_c;
          b_lit      <= blit_c;
        end
      end
    end else begin : g_comb
      assign a_opnd     = a_c;
      assign b_opnd     = b_c;
      assign mar_mux_en = mar_c;
      assign b_src      = bsrc_c;
      assign b_lit      = blit_c;
    end
  endgenerate
endmodule

// File: rtl/opsel_unit_chk.sv
module opsel_unit_chk #(
  parameter int DW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      asel,
  input logic [2:0]      bsel,
  input logic [DW/2-1:0] ff,
  input logic            fn_valid,
  input logic [DW/2-1:0] fn_code,
  input logic [DW-1:0]   md_bus,
  input logic [DW-1:0]   ifu_bus,
  input logic [DW-1:0]   q_bus,
  input logic [DW-1:0]   t_bus,
  input logic [DW-1:0]   ext_a_bus,
  input logic [DW-1:0]   rb_bus,
  input logic [DW-1:0]   a_opnd,
  input logic [DW-1:0]   b_opnd,
  input logic            mar_mux_en,
  input logic [1:0]      b_src,
  input logic            b_lit
);
  localparam int LW = DW / 2;

  generate
    if (REG_OUT) begin : g_chk
      p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (a_opnd == '0 && b_opnd == '0 && !mar_mux_en && !b_lit && b_src == 2'd0));

      p_ifu_select_r2: assert property (@(posedge clk) disable iff (rst)
        (asel == 3'd5 && !fn_valid) |=> a_opnd == $past(ifu_bus));

      p_ff_md_select_r3: assert property (@(posedge clk) disable iff (rst)
        (asel[2:1] == 2'b01 && fn_valid && fn_code == LW'(8'h05) && ff[LW-1:LW-2] == 2'd0)
        |=> a_opnd == $past(md_bus));

      p_invalid_t_r4: assert property (@(posedge clk) disable iff (rst)
        (asel[2:1] == 2'b01 && !fn_valid) |=> a_opnd == $past(t_bus));

      p_mar_on_r5: assert property (@(posedge clk) disable iff (rst)
        (asel < 3'd2) |=> mar_mux_en);

      p_mar_off_r5: assert property (@(posedge clk) disable iff (rst)
        (asel >= 3'd2) |=> !mar_mux_en);

      p_force_md_r6: assert property (@(posedge clk) disable iff (rst)
        (fn_valid && fn_code == LW'(8'o22)) |=> a_opnd == $past(md_bus));

      p_regbus_b_r7: assert property (@(posedge clk) disable iff (rst)
        (bsel < 3'd4) |=> (b_opnd == $past(rb_bus) && b_src == $past(bsel[1:0]) && !b_lit));

      p_lit_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (bsel == 3'd5) |=> (b_opnd[DW-1:LW] == {LW{1'b1}} && b_opnd[LW-1:0] == $past(ff) && b_lit));

      p_lit_swap_r9: assert property (@(posedge clk) disable iff (rst)
        (bsel == 3'd6) |=> (b_opnd == {$past(ff), {LW{1'b0}}} && b_lit));

      p_no_force_r11: assert property (@(posedge clk) disable iff (rst)
        (asel == 3'd6 && !fn_valid) |=> a_opnd == $past(t_bus));
    end
  endgenerate
endmodule

bind opsel_unit opsel_unit_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .asel(asel), .bsel(bsel), .ff(ff),
  .fn_valid(fn_valid), .fn_code(fn_code), .md_bus(md_bus),
  .ifu_bus(ifu_bus), .q_bus(q_bus), .t_bus(t_bus),
  .ext_a_bus(ext_a_bus), .rb_bus(rb_bus), .a_opnd(a_opnd),
  .b_opnd(b_opnd), .mar_mux_en(mar_mux_en), .b_src(b_src), .b_lit(b_lit)
);

// File: tb/sim_opsel_unit.sv
module sim_opsel_unit;
  localparam int DW = 16;
  localparam logic [15:0] MDV = 16'h1111, IFV = 16'h2222, QV = 16'h3333;
  localparam logic [15:0] TV = 16'h4444, EXV = 16'h5555, RBV = 16'h6666;

  // {req4, asel3, bsel3, ff8, fv1, fc8, exp_src3 (0 md,1 ifu,2 q,3 t,4 ext), mar1, bsrc2, lit1, expb16}
  localparam int NV = 16;
  localparam logic [49:0] VEC [0:NV-1] = '{
    {4'd2,  3'd5, 3'd0, 8'h00, 1'b0, 8'h00, 3'd1, 1'b0, 2'd0, 1'b0, 16'h6666}, // R2 R7
    {4'd2,  3'd6, 3'd1, 8'h00, 1'b0, 8'h00, 3'd3, 1'b0, 2'd1, 1'b0, 16'h6666}, // R2 R7
    {4'd3,  3'd2, 3'd2, 8'h05, 1'b1, 8'h05, 3'd0, 1'b0, 2'd2, 1'b0, 16'h6666}, // R3 R7
    {4'd3,  3'd3, 3'd3, 8'h41, 1'b1, 8'h41, 3'd1, 1'b0, 2'd3, 1'b0, 16'h6666}, // R3 R7
    {4'd8,  3'd2, 3'd4, 8'h80, 1'b1, 8'h80, 3'd2, 1'b0, 2'd0, 1'b1, 16'h0080}, // R3 R8
    {4'd8,  3'd3, 3'd5, 8'hC3, 1'b1, 8'hC3, 3'd3, 1'b0, 2'd0, 1'b1, 16'hFFC3}, // R3 R8
    {4'd9,  3'd2, 3'd6, 8'h3C, 1'b0, 8'h00, 3'd3, 1'b0, 2'd0, 1'b1, 16'h3C00}, // R4 R9
    {4'd9,  3'd0, 3'd7, 8'h5A, 1'b0, 8'h00, 3'd4, 1'b1, 2'd0, 1'b1, 16'h5AFF}, // R5 R9
    {4'd5,  3'd1, 3'd0, 8'h00, 1'b0, 8'h00, 3'd4, 1'b1, 2'd0, 1'b0, 16'h6666}, // R5
    {4'd5,  3'd4, 3'd0, 8'h00, 1'b0, 8'h00, 3'd4, 1'b0, 2'd0, 1'b0, 16'h6666}, // R5
    {4'd5,  3'd7, 3'd0, 8'h00, 1'b0, 8'h00, 3'd4, 1'b0, 2'd0, 1'b0, 16'h6666}, // R5
    {4'd6,  3'd5, 3'd4, 8'h11, 1'b1, 8'o21, 3'd3, 1'b0, 2'd0, 1'b1, 16'h0011}, // R6
    {4'd6,  3'd6, 3'd5, 8'h12, 1'b1, 8'o22, 3'd0, 1'b0, 2'd0, 1'b1, 16'hFF12}, // R6
    {4'd6,  3'd0, 3'd6, 8'h13, 1'b1, 8'o23, 3'd2, 1'b1, 2'd0, 1'b1, 16'h1300}, // R6 R5
    {4'd6,  3'd2, 3'd0, 8'h11, 1'b1, 8'o21, 3'd3, 1'b0, 2'd0, 1'b0, 16'h6666}, // R6 over ff
    {4'd11, 3'd6, 3'd0, 8'h12, 1'b0, 8'o22, 3'd3, 1'b0, 2'd0, 1'b0, 16'h6666}  // R11
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] asel = '0, bsel = '0;
  logic [7:0] ff = '0, fn_code = '0;
  logic fn_valid = 1'b0;
  logic [DW-1:0] a_opnd, b_opnd;
  logic mar_mux_en, b_lit;
  logic [1:0] b_src;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opsel_unit #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .asel(asel), .bsel(bsel), .ff(ff),
    .fn_valid(fn_valid), .fn_code(fn_code), .md_bus(MDV), .ifu_bus(IFV),
    .q_bus(QV), .t_bus(TV), .ext_a_bus(EXV), .rb_bus(RBV),
    .a_opnd(a_opnd), .b_opnd(b_opnd), .mar_mux_en(mar_mux_en),
    .b_src(b_src), .b_lit(b_lit)
  );

  function automatic logic [15:0] src_val(input logic [2:0] s);
    case (s)
      3'd0: return MDV;
      3'd1: return IFV;
      3'd2: return QV;
      3'd3: return TV;
      default: return EXV;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] a, input logic [2:0] b, input logic [7:0] f,
                       input logic v, input logic [7:0] c);
    asel = a; bsel = b; ff = f; fn_valid = v; fn_code = c;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    drive(3'd6, 3'd5, 8'hAB, 1'b0, 8'h00);
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 a", a_opnd, 0);
    check("R1 b", b_opnd, 0);
    check("R1 ctl", {mar_mux_en, b_lit, b_src}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      string tag;
      v = VEC[i];
      drive(v[45:43], v[42:40], v[39:32], v[31], v[30:23]);
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", v[49:46], i);
      check({tag, " a"}, a_opnd, src_val(v[22:20]));
      check({tag, " mar"}, mar_mux_en, v[19]);
      check({tag, " bsrc"}, b_src, v[18:17]);
      check({tag, " lit"}, b_lit, v[16]);
      check({tag, " b"}, b_opnd, v[15:0]);
    end

    // R10: new inputs do not show before the next edge
    drive(3'd5, 3'd7, 8'h99, 1'b0, 8'h00);
    @(negedge clk);
    drive(3'd6, 3'd4, 8'h01, 1'b0, 8'h00);
    #2;
    check("R10 hold a", a_opnd, IFV);
    check("R10 hold b", b_opnd, 16'h99FF);
    @(negedge clk);
    check("R10 update a", a_opnd, TV);
    check("R10 update b", b_opnd, 16'h0001);

    // R6 with R5: override on asel 1 keeps mar enable, literal B unaffected
    drive(3'd1, 3'd7, 8'h12, 1'b1, 8'o22);
    @(negedge clk);
    check("R6 a", a_opnd, MDV);
    check("R5 mar", mar_mux_en, 1'b1);
    check("R9 b", b_opnd, 16'h12FF);

    // R1: mid-run reset clears
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid a", a_opnd, 0);
    check("R1 mid b", b_opnd, 0);
    check("R1 mid mar", mar_mux_en, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 release a", a_opnd, MDV);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule